// File: doc/BRIEF.md
# Steered PWM Generator with Dead Band and Auto-Shutdown

This block produces a pulse-width-modulated waveform from a prescaled timer and steers it onto four pins, A to D. Software sets the period, the duty, the steering mode, the polarity of each pin pair, a dead-band gap for half-bridge use, and the shutdown behaviour through a byte-wide write port. A set of external fault inputs can force the pins to safe levels. The forced state holds until software releases it, or until the next period boundary if automatic restart is enabled.

The time base is a fine counter made of the 8-bit timer value with two extra low bits appended. Each prescaled tick advances the fine counter by one, so one period lasts 4*(P+1) ticks. Pin A is logically active while the fine counter is below the 10-bit duty. Duty and period written while the timer runs are applied only at the next rollover. While the timer is off, the counters are held at zero and the written values take effect at once.

The write map is as follows. Address 0 holds the period P. Address 1 holds the upper eight duty bits. Address 2 holds the configuration byte. Address 3 holds the dead band and the restart bit. Address 4 holds the shutdown control. Address 5 holds the timer control.

Top module: `pwm_steer`

## Requirements
- R1: After reset all pin enables are 0, all pins are 0, and both flags are 0.
- R2: The fine counter restarts after 4*(P+1) ticks. The logical PWM signal is active while the fine count is below the duty value, which is {address 1, configuration bits [1:0]}. A duty of 0 is never active, and a duty of at least 4*(P+1) is always active.
- R3: Configuration bits [7:6] select the prescale: 00 gives 1 clock per tick, 01 gives 4, and 1x gives 16. Timer-control bit 0 enables the timer. While it is 0, the counters are held at zero.
- R4: Each rollover sets tmr_flag_o. Writing address 5 with bit 2 set clears the flag, but a rollover in the same cycle wins.
- R5: While the timer runs, newly written duty and period values apply only from the next rollover.
- R6: Configuration bits [3:2] select the steering mode, with pin enables masked by timer-control bit 1. 00 is single: A carries PWM and only A is enabled. 01 is half-bridge: A carries PWM, B carries its complement, and A and B are enabled. 10 is forward: A is held active, D carries PWM, and all four are enabled. 11 is reverse: B is held active, C carries PWM, and all four are enabled. Unused pins sit at their inactive level.
- R7: Configuration bit 4 makes A and C active-low, and bit 5 makes B and D active-low.
- R8: In half-bridge mode, each edge of the PWM signal turns both A and B inactive for D clocks before the other one turns on. D is address 3 bits [6:0], and D = 0 gives no gap.
- R9: Shutdown sources are selected by address 4 bits [2:0]. A selected source that is high sets shdn_flag_o at the next edge. Unselected sources have no effect.
- R10: While shdn_flag_o is set, A/C use address 4 bits [4:3] and B/D use bits [6:5]. 00 drives 0, 01 drives 1, and 1x turns the pin enable off.
- R11: Without restart, the flag stays set until a write to address 4 with bit 7 at 0. A selected source still high at that write keeps the flag set. Writing bit 7 as 1 sets the flag directly.
- R12: With address 3 bit 7 set, the flag clears at the first rollover at which no selected source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| shdn_src_i | input | 3 | External shutdown sources |
| pwm_o | output | 4 | Pin levels, bit 0 = A to bit 3 = D |
| pwm_oe_o | output | 4 | Pin enables, same order |
| shdn_flag_o | output | 1 | Shutdown-event flag |
| tmr_flag_o | output | 1 | Timer rollover flag |

## Verification
The shutdown flag can be set by a fault source in the same cycle that would clear it, either at a period rollover with restart enabled or by a software release write. The bench holds a selected source high across the rollover edge, and separately across the clearing write. In both cases it checks that the flag is still set one sample later, and that it drops only at the following rollover or at a later write once the source is low. The same priority between setting and clearing is exercised for the timer flag, where a clearing write is followed by a rollover.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_FWD    = 2'b10,
    MODE_REV    = 2'b11
  } steer_mode_e;

  localparam logic [2:0] ADDR_PER = 3'd0;
  localparam logic [2:0] ADDR_DHI = 3'd1;
  localparam logic [2:0] ADDR_CFG = 3'd2;
  localparam logic [2:0] ADDR_DB  = 3'd3;
  localparam logic [2:0] ADDR_SHD = 3'd4;
  localparam logic [2:0] ADDR_TMR = 3'd5;

  localparam int PSC_W = 4;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwm_steer_pkg::*; #(
  parameter int PER_W = 8,
  parameter int LO_W  = 2,
  localparam int CNT_W = PER_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       psc_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             active_o,
  output logic             roll_o
);
  logic [PSC_W-1:0] psc_cnt_q, psc_lim;
  logic [CNT_W-1:0] fine_q, duty_act_q;
  logic [PER_W-1:0] per_act_q;
  logic             tick;

  always_comb begin
    unique case (psc_i)
      2'b00:   psc_lim = PSC_W'(0);
      2'b01:   psc_lim = PSC_W'(3);
      default: psc_lim = PSC_W'(15);
    endcase
  end

  assign tick   = en_i && (psc_cnt_q == psc_lim);
  assign roll_o = tick && (fine_q == {per_act_q, {LO_W{1'b1}}});
  assign active_o = fine_q < duty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q  <= '0;
      fine_q     <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else if (!en_i) begin
      psc_cnt_q  <= '0;
      fine_q     <= '0;
      per_act_q  <= per_i;
      duty_act_q <= duty_i;
    end else begin
      psc_cnt_q <= tick ? '0 : psc_cnt_q + 1'b1;
      if (roll_o) begin
        fine_q     <= '0;
        per_act_q  <= per_i;
        duty_act_q <= duty_i;
      end else if (tick) begin
        fine_q <= fine_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DB_W-1:0] db_i,
  output logic            a_o,
  output logic            b_o
);
  logic            raw_q, chg, blank;
  logic [DB_W-1:0] cnt_q;

  assign chg   = raw_i != raw_q;
  // the edge cycle itself is the first blanked clock
  assign blank = chg ? (db_i != '0) : (cnt_q != '0);
  assign a_o   = raw_i & ~blank;
  assign b_o   = ~raw_i & ~blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      raw_q <= raw_i;
      if (chg)               cnt_q <= (db_i == '0) ? '0 : db_i - 1'b1;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_outmux.sv
module pwm_outmux import pwm_steer_pkg::*; #(
  parameter int PIN_N = 4
) (
  input  steer_mode_e      mode_i,
  input  logic             raw_i,
  input  logic             db_a_i,
  input  logic             db_b_i,
  input  logic             pol_ac_i,
  input  logic             pol_bd_i,
  input  logic             out_en_i,
  input  logic             shdn_i,
  input  logic [1:0]       st_ac_i,
  input  logic [1:0]       st_bd_i,
  output logic [PIN_N-1:0] pin_o,
  output logic [PIN_N-1:0] oe_o
);
  logic [PIN_N-1:0] act, mask;

  always_comb begin
    act  = '0;
    mask = '0;
    unique case (mode_i)
      MODE_SINGLE: begin act[0] = raw_i;                   mask[0]   = 1'b1; end
      MODE_HALF:   begin act[0] = db_a_i; act[1] = db_b_i; mask[1:0] = 2'b11; end
      MODE_FWD:    begin act[0] = 1'b1;   act[3] = raw_i;  mask      = '1;    end
      MODE_REV:    begin act[1] = 1'b1;   act[2] = raw_i;  mask      = '1;    end
      default: ;
    endcase
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    logic       pol;
    logic [1:0] st;
    if (i % 2 == 0) begin : g_ac
      assign pol = pol_ac_i;
      assign st  = st_ac_i;
    end else begin : g_bd
      assign pol = pol_bd_i;
      assign st  = st_bd_i;
    end
    assign pin_o[i] = shdn_i ? (~st[1] & st[0]) : (act[i] ^ pol);
    assign oe_o[i]  = out_en_i & mask[i] & ~(shdn_i & st[1]);
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer import pwm_steer_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int LO_W   = 2,
  parameter int SRC_N  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SRC_N-1:0]  shdn_src_i,
  output logic [3:0]        pwm_o,
  output logic [3:0]        pwm_oe_o,
  output logic              shdn_flag_o,
  output logic              tmr_flag_o
);
  localparam int PER_W = DATA_W;
  localparam int DB_W  = DATA_W - 1;
  localparam int CNT_W = PER_W + LO_W;
  localparam int ST_LO = SRC_N;

  logic [PER_W-1:0]  per_q, dhi_q;
  logic [DATA_W-1:0] cfg_q;
  logic [DB_W-1:0]   db_q;
  logic              auto_q, tmr_en_q, out_en_q;
  logic [SRC_N-1:0]  sel_q;
  logic [1:0]        st_ac_q, st_bd_q;
  logic              shdn_q, tflag_q;
  logic              wr_shd, wr_tmr, hit, raw, roll, db_a, db_b;
  steer_mode_e       mode;
  logic              unused_tmr_bits;

  assign mode   = steer_mode_e'(cfg_q[LO_W+1:LO_W]);
  assign wr_shd = wr_en_i && (wr_addr_i == ADDR_SHD);
  assign wr_tmr = wr_en_i && (wr_addr_i == ADDR_TMR);
  assign hit    = |(shdn_src_i & sel_q);
  assign unused_tmr_bits = ^wr_data_i[DATA_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0; dhi_q <= '0; cfg_q <= '0; db_q <= '0; auto_q <= 1'b0;
      sel_q <= '0; st_ac_q <= '0; st_bd_q <= '0;
      tmr_en_q <= 1'b0; out_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PER: per_q <= wr_data_i;
        ADDR_DHI: dhi_q <= wr_data_i;
        ADDR_CFG: cfg_q <= wr_data_i;
        ADDR_DB:  begin db_q <= wr_data_i[DB_W-1:0]; auto_q <= wr_data_i[DATA_W-1]; end
        ADDR_SHD: begin
          sel_q   <= wr_data_i[SRC_N-1:0];
          st_ac_q <= wr_data_i[ST_LO+1:ST_LO];
          st_bd_q <= wr_data_i[ST_LO+3:ST_LO+2];
        end
        ADDR_TMR: begin tmr_en_q <= wr_data_i[0]; out_en_q <= wr_data_i[1]; end
        default: ;
      endcase
    end
  end

  // set has priority over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shdn_q  <= 1'b0;
      tflag_q <= 1'b0;
    end else begin
      if (hit)                 shdn_q <= 1'b1;
      else if (wr_shd)         shdn_q <= wr_data_i[DATA_W-1];
      else if (auto_q && roll) shdn_q <= 1'b0;
      if (roll)                          tflag_q <= 1'b1;
      else if (wr_tmr && wr_data_i[2])   tflag_q <= 1'b0;
    end
  end

  pwm_timebase #(.PER_W(PER_W), .LO_W(LO_W)) i_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tmr_en_q),
    .psc_i    (cfg_q[LO_W+5:LO_W+4]),
    .per_i    (per_q),
    .duty_i   ({dhi_q, cfg_q[LO_W-1:0]}),
    .active_o (raw),
    .roll_o   (roll)
  );

  pwm_deadband #(.DB_W(DB_W)) i_deadband (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .db_i   (db_q),
    .a_o    (db_a),
    .b_o    (db_b)
  );

  pwm_outmux #(.PIN_N(4)) i_outmux (
    .mode_i   (mode),
    .raw_i    (raw),
    .db_a_i   (db_a),
    .db_b_i   (db_b),
    .pol_ac_i (cfg_q[LO_W+2]),
    .pol_bd_i (cfg_q[LO_W+3]),
    .out_en_i (out_en_q),
    .shdn_i   (shdn_q),
    .st_ac_i  (st_ac_q),
    .st_bd_i  (st_bd_q),
    .pin_o    (pwm_o),
    .oe_o     (pwm_oe_o)
  );

  assign shdn_flag_o = shdn_q;
  assign tmr_flag_o  = tflag_q;
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int DATA_W = 8,
  parameter int SRC_N  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [SRC_N-1:0]  shdn_src_i,
  input logic [SRC_N-1:0]  sel_i,
  input logic [1:0]        st_ac_i,
  input logic [1:0]        mode_i,
  input logic              pol_ac_i,
  input logic              pol_bd_i,
  input logic              auto_i,
  input logic [3:0]        pwm_o,
  input logic [3:0]        pwm_oe_o,
  input logic              shdn_flag_o,
  input logic              tmr_flag_o
);
  AST_SHDN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(shdn_src_i & sel_i)) |=> shdn_flag_o); // R9

  AST_SHDN_TRI_AC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_flag_o && st_ac_i[1]) |-> (!pwm_oe_o[0] && !pwm_oe_o[2])); // R10

  AST_SINGLE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (pwm_oe_o[3:1] == 3'b000)); // R6

  AST_DB_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !pol_ac_i && !pol_bd_i && !shdn_flag_o) |-> !(pwm_o[0] && pwm_o[1])); // R8

  AST_TFLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_flag_o && !(wr_en_i && wr_addr_i == 3'd5 && wr_data_i[2])) |=> tmr_flag_o); // R4

  AST_SHDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_flag_o && !auto_i && !(wr_en_i && wr_addr_i == 3'd4)) |=> shdn_flag_o); // R11
endmodule

bind pwm_steer pwm_steer_chk #(.DATA_W(DATA_W), .SRC_N(SRC_N)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .shdn_src_i  (shdn_src_i),
  .sel_i       (sel_q),
  .st_ac_i     (st_ac_q),
  .mode_i      (cfg_q[LO_W+1:LO_W]),
  .pol_ac_i    (cfg_q[LO_W+2]),
  .pol_bd_i    (cfg_q[LO_W+3]),
  .auto_i      (auto_q),
  .pwm_o       (pwm_o),
  .pwm_oe_o    (pwm_oe_o),
  .shdn_flag_o (shdn_flag_o),
  .tmr_flag_o  (tmr_flag_o)
);

// File: tb/test_pwm_steer.sv
module test_pwm_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] src = '0;
  logic [3:0] pins, oe;
  logic       shdn, tflag;
  int         n_chk = 0, n_fail = 0, ecnt = 0, e0 = 0;
  bit         done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  pwm_steer i_pwm_steer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .shdn_src_i(src), .pwm_o(pins), .pwm_oe_o(oe),
    .shdn_flag_o(shdn), .tmr_flag_o(tflag)
  );

  // mode, pol{bd,ac}, duty, dead band, sample tick, pins DCBA, enables DCBA; period 3
  localparam int NV = 20;
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 2'b00, 10'd6,    7'd2, 5'd3,  4'b0001, 4'b0001}, // R2 R6
    {2'b00, 2'b00, 10'd6,    7'd2, 5'd9,  4'b0000, 4'b0001}, // R2
    {2'b00, 2'b01, 10'd6,    7'd2, 5'd3,  4'b0100, 4'b0001}, // R7
    {2'b00, 2'b01, 10'd6,    7'd2, 5'd9,  4'b0101, 4'b0001}, // R7
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd3,  4'b0001, 4'b0011}, // R6 R8
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd6,  4'b0000, 4'b0011}, // R8
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd7,  4'b0000, 4'b0011}, // R8
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd9,  4'b0010, 4'b0011}, // R8
    {2'b01, 2'b00, 10'd6,    7'd0, 5'd6,  4'b0010, 4'b0011}, // R8 zero gap
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd17, 4'b0000, 4'b0011}, // R8 R2 wrap
    {2'b01, 2'b00, 10'd6,    7'd2, 5'd18, 4'b0001, 4'b0011}, // R8
    {2'b10, 2'b00, 10'd6,    7'd2, 5'd3,  4'b1001, 4'b1111}, // R6
    {2'b10, 2'b00, 10'd6,    7'd2, 5'd9,  4'b0001, 4'b1111}, // R6
    {2'b11, 2'b00, 10'd6,    7'd2, 5'd3,  4'b0110, 4'b1111}, // R6
    {2'b11, 2'b00, 10'd6,    7'd2, 5'd9,  4'b0010, 4'b1111}, // R6
    {2'b11, 2'b11, 10'd6,    7'd2, 5'd3,  4'b1001, 4'b1111}, // R7
    {2'b10, 2'b10, 10'd6,    7'd2, 5'd9,  4'b1011, 4'b1111}, // R7
    {2'b00, 2'b00, 10'd0,    7'd2, 5'd3,  4'b0000, 4'b0001}, // R2 duty 0
    {2'b00, 2'b00, 10'd16,   7'd2, 5'd15, 4'b0001, 4'b0001}, // R2 full
    {2'b00, 2'b00, 10'd1023, 7'd2, 5'd9,  4'b0001, 4'b0001}  // R2 over
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, ecnt);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic start();
    wr(3'd5, 8'h03);
    e0 = ecnt;
  endtask

  task automatic wait_e(input int n);
    do @(negedge clk); while (ecnt - e0 < n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins", {4'b0, pins}, 8'h00);
    chk("R1 enables", {4'b0, oe}, 8'h00);
    chk("R1 flags", {6'b0, shdn, tflag}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      e = VEC[v];
      wr(3'd5, 8'h00);
      wr(3'd0, 8'd3);
      wr(3'd1, e[29:22]);
      wr(3'd2, {2'b00, e[31:30], e[33:32], e[21:20]});
      wr(3'd3, {1'b0, e[19:13]});
      wr(3'd4, 8'h00);
      start();
      wait_e(int'(e[12:8]));
      chk("R2 R6 R7 R8 pins", {4'b0, pins}, {4'b0, e[7:4]});
      chk("R6 enables", {4'b0, oe}, {4'b0, e[3:0]});
    end

    // R3 prescale 4, period 0, duty 2
    wr(3'd5, 8'h04);
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd0);
    wr(3'd2, 8'b01_0_0_00_10);
    start();
    wait_e(7);  chk("R3 tick at 4 clocks", {7'b0, pins[0]}, 8'd1);
    wait_e(8);  chk("R3 duty end", {7'b0, pins[0]}, 8'd0);
    wait_e(15); chk("R4 flag before rollover", {7'b0, tflag}, 8'd0);
    wait_e(16); chk("R4 flag at rollover", {7'b0, tflag}, 8'd1);
    wr(3'd5, 8'h07);
    @(negedge clk); chk("R4 flag clear", {7'b0, tflag}, 8'd0);

    // R3 prescale 16
    wr(3'd5, 8'h04);
    wr(3'd2, 8'b10_0_0_00_10);
    start();
    wait_e(63); chk("R3 div16 before", {7'b0, tflag}, 8'd0);
    wait_e(64); chk("R3 div16 rollover", {7'b0, tflag}, 8'd1);

    // R5 deferred duty and period
    wr(3'd5, 8'h04);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd1);
    wr(3'd2, 8'b00_0_0_00_10);
    start();
    wr(3'd1, 8'd3);
    wait_e(8);  chk("R5 old duty kept", {7'b0, pins[0]}, 8'd0);
    wait_e(24); chk("R5 new duty applied", {7'b0, pins[0]}, 8'd1);
    wr(3'd0, 8'd7);
    wait_e(32); chk("R5 rollover on old period", {7'b0, tflag}, 8'd1);
    wr(3'd5, 8'h07);
    wait_e(48); chk("R5 new period not yet", {7'b0, tflag}, 8'd0);
    wait_e(64); chk("R5 new period rollover", {7'b0, tflag}, 8'd1);

    // R9 R10 R11 shutdown, half-bridge, no restart
    wr(3'd5, 8'h04);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd1);
    wr(3'd2, 8'b00_0_0_01_10);
    wr(3'd3, 8'h02);
    wr(3'd4, 8'h49);
    start();
    wait_e(1); src = 3'b010;
    wait_e(3);
    chk("R9 unselected ignored", {7'b0, shdn}, 8'd0);
    chk("R9 pins unaffected", {oe, pins}, 8'b0011_0001);
    src = 3'b001;
    wait_e(4);
    chk("R9 flag set", {7'b0, shdn}, 8'd1);
    chk("R10 forced states", {oe, pins}, 8'b0001_0101);
    src = 3'b000;
    wait_e(40); chk("R11 flag held", {7'b0, shdn}, 8'd1);
    src = 3'b001;
    wr(3'd4, 8'h49);
    @(negedge clk); chk("R11 source beats clear", {7'b0, shdn}, 8'd1);
    src = 3'b000;
    wr(3'd4, 8'h49);
    @(negedge clk);
    chk("R11 software clear", {7'b0, shdn}, 8'd0);
    chk("R11 enables restored", {4'b0, oe}, 8'b0000_0011);
    wr(3'd4, 8'hA0);
    @(negedge clk);
    chk("R11 software set", {7'b0, shdn}, 8'd1);
    chk("R10 drive 0 and 1", {oe, pins}, 8'b0011_1010);
    wr(3'd4, 8'h00);

    // R12 auto-restart
    wr(3'd5, 8'h04);
    wr(3'd3, 8'h82);
    wr(3'd4, 8'h49);
    start();
    wait_e(1); src = 3'b001;
    wait_e(4); src = 3'b000;
    chk("R12 set", {7'b0, shdn}, 8'd1);
    wait_e(15); chk("R12 held to boundary", {7'b0, shdn}, 8'd1);
    wait_e(16); chk("R12 released at rollover", {7'b0, shdn}, 8'd0);
    wait_e(31); src = 3'b001;
    wait_e(32); src = 3'b000;
    chk("R12 source at rollover", {7'b0, shdn}, 8'd1);
    wait_e(47); chk("R12 held again", {7'b0, shdn}, 8'd1);
    wait_e(48); chk("R12 second release", {7'b0, shdn}, 8'd0);

    finish_run();
  end
endmodule